// File: doc/BRIEF.md
# Processor power-up sequencer

This block generates the two active-low power-status lines that a processor samples after power is applied. One line reports that the DC supply is good and the other reports that the AC supply is good. Both lines are held low while power-on reset is active. The DC line is released first, after a minimum number of input clock cycles. The AC line is released only after a second minimum count, and that count starts when the DC line goes high. The two lines are never released together, and the AC line is never released first. Once both lines are high, a done flag rises and stays high.

Each delay can be set at run time through an input. A requested value below the floor set by the corresponding parameter is raised to that floor. The parameters are checked during elaboration, and values below 5 (DC) or 10 (AC) are rejected.

The block also drives a half-rate copy of the input clock, which can be used for monitoring. The reset input is asynchronous and active low. It is released through a two-stage synchronizer. Asserting it at any time pulls both status lines low and restarts the sequence.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, `dc_lo_no`, `ac_lo_no`, `seq_done_o` and `clk_half_o` are all 0.
- R2: Let D be the larger of `dc_dly_i` and `DC_MIN`. `dc_lo_no` goes high on exactly the (D+2)-th rising clock edge after `rst_ni` is released. Two of those edges are spent in the reset synchronizer.
- R3: Let A be the larger of `ac_dly_i` and `AC_MIN`. `ac_lo_no` goes high on exactly the A-th rising edge after the edge on which `dc_lo_no` went high.
- R4: `ac_lo_no` is never high while `dc_lo_no` is low, and the two lines never rise on the same edge.
- R5: `clk_half_o` stays 0 through the 2nd edge after reset release. It goes to 1 on the 3rd edge and then toggles on every rising edge.
- R6: `seq_done_o` rises on the same edge as `ac_lo_no` and stays high until reset.
- R7: Pulling `rst_ni` low in the middle of a sequence immediately forces both lines low. After release, the full sequence restarts from the beginning with the R2 and R3 timing.
- R8: A run-time delay input below its floor (including 0) behaves as if the floor value (`DC_MIN` or `AC_MIN`) had been applied.
- R9: After both lines are released, `dc_lo_no`, `ac_lo_no` and `seq_done_o` remain high for as long as reset stays deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor input clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| dc_dly_i | input | CNT_W | Requested DC release delay in cycles (floored to DC_MIN) |
| ac_dly_i | input | CNT_W | Requested AC release delay in cycles (floored to AC_MIN) |
| dc_lo_no | output | 1 | DC power status line, low = not yet good |
| ac_lo_no | output | 1 | AC power status line, low = not yet good |
| seq_done_o | output | 1 | High once both lines are released |
| clk_half_o | output | 1 | Input clock divided by two |

## Verification
The hardest case is a reset that arrives while the DC line is already high but the AC line is still counting. In that state the shared counter holds a partial value, and a missing clear would shorten the next sequence. The bench lets the DC line rise and waits a few edges. It then pulls reset low between clock edges and checks that both lines drop at once. Finally it reruns the whole sequence with different delay inputs and measures the exact edge of each release again.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  // Absolute floors the processor needs between power-on and each release
  localparam int unsigned DC_FLOOR = 5;
  localparam int unsigned AC_FLOOR = 10;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_DC   = 2'd1,
    ST_BOTH = 2'd2
  } seq_st_e;

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;

endmodule

// File: rtl/pwrup_clkdiv.sv
module pwrup_clkdiv (
  input  logic clk,
  input  logic rst_sn,
  output logic clk_half
);

  logic half_q;
  logic half_d;

  always_comb begin
    half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) half_q <= 1'b0;
    else         half_q <= half_d;
  end

  assign clk_half = half_q;

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import pwrup_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DC_MIN = 5,
  parameter int unsigned AC_MIN = 10
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [CNT_W-1:0] dc_dly,
  input  logic [CNT_W-1:0] ac_dly,
  output logic             dc_lo_n,
  output logic             ac_lo_n,
  output logic             done
);

  localparam logic [CNT_W-1:0] DC_MIN_C = CNT_W'(DC_MIN);
  localparam logic [CNT_W-1:0] AC_MIN_C = CNT_W'(AC_MIN);

  seq_st_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] dc_eff, ac_eff;

  // Raise requested delays to their floors
  always_comb begin
    dc_eff = (dc_dly < DC_MIN_C) ? DC_MIN_C : dc_dly;
    ac_eff = (ac_dly < AC_MIN_C) ? AC_MIN_C : ac_dly;
  end

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: if (cnt_q == dc_eff - 1'b1) state_d = ST_DC;
      ST_DC:   if (cnt_q == ac_eff - 1'b1) state_d = ST_BOTH;
      default: state_d = ST_BOTH;
    endcase
  end

  // Shared counter: cleared on every state change, frozen at the end
  always_comb begin
    cnt_en = (state_q != ST_BOTH);
    if (state_d != state_q) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_HOLD;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    dc_lo_n = (state_q != ST_HOLD);
    ac_lo_n = (state_q == ST_BOTH);
    done    = (state_q == ST_BOTH);
  end

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DC_MIN = 5,
  parameter int unsigned AC_MIN = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] dc_dly_i,
  input  logic [CNT_W-1:0] ac_dly_i,
  output logic             dc_lo_no,
  output logic             ac_lo_no,
  output logic             seq_done_o,
  output logic             clk_half_o
);

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  generate
    if (DC_MIN < DC_FLOOR || AC_MIN < AC_FLOOR ||
        DC_MIN > CNT_MAX || AC_MIN > CNT_MAX) begin : g_bad_param
      $error("pwrup_seq: delay floors below 5/10 or beyond counter range");
    end
  endgenerate

  logic rst_s;

  pwrup_rst_sync i_rst_sync (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .rst_sn (rst_s)
  );

  pwrup_clkdiv i_clkdiv (
    .clk      (clk_i),
    .rst_sn   (rst_s),
    .clk_half (clk_half_o)
  );

  pwrup_fsm #(
    .CNT_W  (CNT_W),
    .DC_MIN (DC_MIN),
    .AC_MIN (AC_MIN)
  ) i_fsm (
    .clk     (clk_i),
    .rst_sn  (rst_s),
    .dc_dly  (dc_dly_i),
    .ac_dly  (ac_dly_i),
    .dc_lo_n (dc_lo_no),
    .ac_lo_n (ac_lo_no),
    .done    (seq_done_o)
  );

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
  parameter int unsigned DC_MIN = 5,
  parameter int unsigned AC_MIN = 10
) (
  input logic clk,
  input logic rst_n,
  input logic rst_s,
  input logic dc_lo_n,
  input logic ac_lo_n,
  input logic done,
  input logic clk_half
);

  logic [15:0] since_rst_q;
  logic [15:0] since_dc_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      since_rst_q <= '0;
      since_dc_q  <= '0;
    end else begin
      if (since_rst_q != 16'hFFFF) since_rst_q <= since_rst_q + 16'd1;
      if (dc_lo_n && since_dc_q != 16'hFFFF) since_dc_q <= since_dc_q + 16'd1;
    end
  end

  // R1 / R7: reset forces every output low
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_low: assert (!dc_lo_n && !ac_lo_n && !done && !clk_half)
        else $error("outputs not low during reset");
    end
  end

  a_r2_dc_min_wait: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(dc_lo_n) |-> since_rst_q >= 16'(DC_MIN));

  a_r3_ac_min_wait: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(ac_lo_n) |-> since_dc_q >= 16'(AC_MIN));

  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    ac_lo_n |-> dc_lo_n);

  a_r4_not_together: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(ac_lo_n) |-> $past(dc_lo_n));

  a_r5_half_toggle: assert property (@(posedge clk) disable iff (!rst_s)
    rst_s |=> clk_half != $past(clk_half));

  a_r6_done_with_ac: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(done) |-> $rose(ac_lo_n));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> done);

  a_r9_dc_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    dc_lo_n |=> dc_lo_n);

endmodule

bind pwrup_seq pwrup_seq_chk #(
  .DC_MIN (DC_MIN),
  .AC_MIN (AC_MIN)
) i_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .rst_s    (rst_s),
  .dc_lo_n  (dc_lo_no),
  .ac_lo_n  (ac_lo_no),
  .done     (seq_done_o),
  .clk_half (clk_half_o)
);

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;

  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [CNT_W-1:0] dc_dly_i;
  logic [CNT_W-1:0] ac_dly_i;
  logic             dc_lo_no, ac_lo_no, seq_done_o, clk_half_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit wd_hit  = 0;

  pwrup_seq #(.CNT_W(CNT_W), .DC_MIN(5), .AC_MIN(10)) i_pwrup_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dc_dly_i   (dc_dly_i),
    .ac_dly_i   (ac_dly_i),
    .dc_lo_no   (dc_lo_no),
    .ac_lo_no   (ac_lo_no),
    .seq_done_o (seq_done_o),
    .clk_half_o (clk_half_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  // Release reset, count edges, measure release points (R2 R3 R4 R5 R6)
  task automatic run_seq(input int dcv, input int acv, input int exp_d, input int exp_a);
    int  dc_edge = -1;
    int  ac_edge = -1;
    int  done_edge = -1;
    bit  order_bad = 0;
    bit  half_bad  = 0;
    dc_dly_i = dcv[CNT_W-1:0];
    ac_dly_i = acv[CNT_W-1:0];
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 1; n <= 400; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (dc_lo_no && dc_edge < 0) dc_edge = n;
      if (ac_lo_no && ac_edge < 0) ac_edge = n;
      if (seq_done_o && done_edge < 0) done_edge = n;
      if (ac_lo_no && (dc_edge < 0 || dc_edge == n)) order_bad = 1;
      if (clk_half_o != ((n >= 3) ? ((n - 2) % 2) : 0)) half_bad = 1;
      if (ac_edge > 0 && n >= ac_edge + 4) break;
    end
    check("R2", "dc release edge", dc_edge, exp_d + 2);
    check("R3", "ac edges after dc", ac_edge - dc_edge, exp_a);
    check("R4", "release order violated", int'(order_bad), 0);
    check("R5", "half clock pattern broken", int'(half_bad), 0);
    check("R6", "done edge", done_edge, ac_edge);
  endtask

  task automatic t_reset_state();
    hold_reset();
    check("R1", "dc_lo_no in reset", int'(dc_lo_no), 0);
    check("R1", "ac_lo_no in reset", int'(ac_lo_no), 0);
    check("R1", "seq_done_o in reset", int'(seq_done_o), 0);
    check("R1", "clk_half_o in reset", int'(clk_half_o), 0);
  endtask

  task automatic t_default_floor();
    hold_reset();
    run_seq(0, 0, 5, 10);          // R8: zero requests take the floors
  endtask

  task automatic t_long_delays();
    hold_reset();
    run_seq(12, 23, 12, 23);
  endtask

  task automatic t_below_floor();
    hold_reset();
    run_seq(3, 9, 5, 10);          // R8: 3 and 9 raised to 5 and 10
  endtask

  task automatic t_mid_reset();
    hold_reset();
    dc_dly_i = 8'd6;
    ac_dly_i = 8'd15;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (12) @(negedge clk_i);  // dc up at edge 8, ac due at edge 23
    check("R7", "dc up before mid reset", int'(dc_lo_no), 1);
    #1 rst_ni = 1'b0;
    #1;
    check("R7", "dc low right after reset", int'(dc_lo_no), 0);
    check("R7", "ac low right after reset", int'(ac_lo_no), 0);
    repeat (2) @(negedge clk_i);
    run_seq(7, 11, 7, 11);         // R7 restart uses full timing
  endtask

  task automatic t_hold_forever();
    hold_reset();
    run_seq(5, 10, 5, 10);
    repeat (300) @(negedge clk_i);
    check("R9", "dc still high", int'(dc_lo_no), 1);
    check("R9", "ac still high", int'(ac_lo_no), 1);
    check("R9", "done still high", int'(seq_done_o), 1);
  endtask

  initial begin
    rst_ni   = 1'b0;
    dc_dly_i = '0;
    ac_dly_i = '0;
    t_reset_state();
    t_default_floor();
    t_long_delays();
    t_below_floor();
    t_mid_reset();
    t_hold_forever();
    if (!wd_hit) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    wd_hit = 1;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule